// File: doc/BRIEF.md
# Ethernet Frame Class Tagger

The tagger sits on a byte-wide receive stream. It inspects each frame's destination address and its first one or two tag headers. On the first byte of every frame it leaves, it attaches a 5-bit class vector. The block holds bytes back in a look-ahead buffer. The first byte of a frame is released only once the frame's first 18 bytes have been accepted, or once the frame's last byte has been accepted. By then every field that feeds the class is known.

Bytes leave in the order they arrived, with their start and end markers unchanged. The output ready signal can stall the stream on any cycle. When the buffer fills, the input is stalled in turn.

The input must be well formed. Every frame starts with a byte marked start and ends with a byte marked end. No start appears inside an open frame.

Top module: `frame_class_tagger`

## Requirements
- R1: While reset is asserted and right after it, out_valid_o is 0 and in_ready_o is 1.
- R2: Class bit 3 (broadcast) is set when frame bytes 0 to 5 are all 0xFF. Exactly one of class bits 4, 3 and 2 is set on every first byte.
- R3: Class bit 2 (multicast) is set when bit 0 of frame byte 0 is 1 and the frame is not broadcast.
- R4: Class bit 4 (unicast) is set when neither bit 3 nor bit 2 is set.
- R5: Class bit 1 (single tag) is set when frame bytes 12 and 13 are 0x81 and 0x00.
- R6: Class bit 0 (stacked tags) is set when bytes 12 and 13 form 0x88A8 or 0x8100 and bytes 16 and 17 are 0x81 and 0x00. Bit 1 is then also set.
- R7: out_class_o carries the vector only on a beat with out_sop_o = 1. It is 0 on every other beat.
- R8: The output byte sequence, with its start and end markers, equals the accepted input sequence. No byte is lost, repeated or added.
- R9: The first byte of a frame is not offered until min(18, frame length) bytes of that frame have been accepted.
- R10: A frame shorter than a field gets flags only from the bytes it contains. Fewer than 6 bytes is never broadcast. Fewer than 14 bytes never sets bit 1. Fewer than 18 bytes never sets bit 0.
- R11: While out_valid_o = 1 and out_ready_i = 0, out_valid_o, out_data_o, out_sop_o, out_eop_o and out_class_o hold on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Input byte |
| in_sop_i | input | 1 | Input byte is the first of a frame |
| in_eop_i | input | 1 | Input byte is the last of a frame |
| in_valid_i | input | 1 | Input byte is present |
| in_ready_o | output | 1 | Block accepts the input byte this cycle |
| out_data_o | output | 8 | Output byte |
| out_sop_o | output | 1 | Output byte is the first of a frame |
| out_eop_o | output | 1 | Output byte is the last of a frame |
| out_class_o | output | 5 | Class vector: unicast, broadcast, multicast, single tag, stacked tags (bit 4 to bit 0) |
| out_valid_o | output | 1 | Output byte is present |
| out_ready_i | input | 1 | Sink takes the output byte this cycle |

## Verification
The bench targets frames that end just before or just after each parsed field: lengths 1, 5, 6, 13, 14, 17 and 18. A parser that ignores how many bytes it has seen would report broadcast from a 5-byte frame, or a tag from half a type field. Outer type 0x88A8 with and without an inner 0x8100 tag checks that bit 0 needs both fields and that bit 1 follows bit 0. Back-to-back short frames fill the class queue. Random stalls on both sides expose a buffer that drops or repeats bytes, lets a frame's first byte through before its fields are known, or pairs a class with the wrong frame.

// File: rtl/tagger_pkg.sv
package tagger_pkg;

  localparam int unsigned LOOKAHEAD = 18;
  localparam int unsigned CNT_W     = $clog2(LOOKAHEAD + 1);
  localparam int unsigned DA_LEN    = 6;
  localparam int unsigned OUTER_HI  = 12;
  localparam int unsigned OUTER_LO  = 13;
  localparam int unsigned INNER_HI  = 16;
  localparam int unsigned INNER_LO  = 17;

  localparam logic [15:0] TPID_CTAG = 16'h8100;
  localparam logic [15:0] TPID_STAG = 16'h88A8;

  typedef struct packed {
    logic ucast;
    logic bcast;
    logic mcast;
    logic vlan;
    logic stack;
  } class_t;

  typedef struct packed {
    logic [7:0] data;
    logic       sop;
    logic       eop;
  } beat_t;

endpackage

// File: rtl/tagger_fifo.sv
module tagger_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [AW:0]      cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

endmodule

// File: rtl/tagger_parser.sv
module tagger_parser
  import tagger_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       beat_i,
  input  logic [7:0] data_i,
  input  logic       sop_i,
  input  logic       eop_i,
  output logic       cls_valid_o,
  output class_t     cls_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n, pos;
  logic             all_ff_q, all_ff_n;
  logic             grp_q, grp_n;
  logic [15:0]      outer_q, outer_n, inner_q, inner_n;
  logic             open_q, act, fin;

  assign pos = sop_i ? '0 : cnt_q;
  assign act = sop_i || open_q;
  assign fin = beat_i && act && (eop_i || pos == CNT_W'(LOOKAHEAD - 1));

  always_comb begin
    cnt_n    = pos + CNT_W'(1);
    all_ff_n = sop_i ? 1'b1  : all_ff_q;
    grp_n    = sop_i ? 1'b0  : grp_q;
    outer_n  = sop_i ? 16'h0 : outer_q;
    inner_n  = sop_i ? 16'h0 : inner_q;
    if (pos == CNT_W'(0)) grp_n = data_i[0];
    if (pos < CNT_W'(DA_LEN)) all_ff_n = all_ff_n && (data_i == 8'hFF);
    if (pos == CNT_W'(OUTER_HI)) outer_n[15:8] = data_i;
    if (pos == CNT_W'(OUTER_LO)) outer_n[7:0]  = data_i;
    if (pos == CNT_W'(INNER_HI)) inner_n[15:8] = data_i;
    if (pos == CNT_W'(INNER_LO)) inner_n[7:0]  = data_i;
  end

  // flags only from fields fully present in the frame
  logic da_seen, outer_seen, inner_seen;
  assign da_seen    = cnt_n >= CNT_W'(DA_LEN);
  assign outer_seen = cnt_n >= CNT_W'(OUTER_LO + 1);
  assign inner_seen = cnt_n >= CNT_W'(INNER_LO + 1);

  always_comb begin
    cls_o.bcast = da_seen && all_ff_n;
    cls_o.mcast = grp_n && !cls_o.bcast;
    cls_o.ucast = !cls_o.bcast && !cls_o.mcast;
    cls_o.stack = inner_seen && (outer_n == TPID_STAG || outer_n == TPID_CTAG)
                  && (inner_n == TPID_CTAG);
    cls_o.vlan  = cls_o.stack || (outer_seen && outer_n == TPID_CTAG);
  end

  assign cls_valid_o = fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      all_ff_q <= 1'b1;
      grp_q    <= 1'b0;
      outer_q  <= '0;
      inner_q  <= '0;
      open_q   <= 1'b0;
    end else if (beat_i && act) begin
      cnt_q    <= cnt_n;
      all_ff_q <= all_ff_n;
      grp_q    <= grp_n;
      outer_q  <= outer_n;
      inner_q  <= inner_n;
      open_q   <= !fin;
    end
  end

endmodule

// File: rtl/frame_class_tagger.sv
module frame_class_tagger
  import tagger_pkg::*;
#(
  parameter int unsigned DATA_DEPTH  = 32,
  parameter int unsigned CLASS_DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] in_data_i,
  input  logic       in_sop_i,
  input  logic       in_eop_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  output logic [7:0] out_data_o,
  output logic       out_sop_o,
  output logic       out_eop_o,
  output logic [4:0] out_class_o,
  output logic       out_valid_o,
  input  logic       out_ready_i
);
  localparam int unsigned BEAT_W  = $bits(beat_t);
  localparam int unsigned CLASS_W = $bits(class_t);

  logic   d_empty, d_full, c_empty, c_full;
  logic   in_fire, out_fire, cls_push;
  beat_t  in_beat, head;
  class_t cls_new, cls_head;
  logic [BEAT_W-1:0]  head_raw;
  logic [CLASS_W-1:0] cls_raw;

  assign in_ready_o = !d_full && !c_full;
  assign in_fire    = in_valid_i && in_ready_o;
  assign in_beat    = '{data: in_data_i, sop: in_sop_i, eop: in_eop_i};

  tagger_parser i_parser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beat_i      (in_fire),
    .data_i      (in_data_i),
    .sop_i       (in_sop_i),
    .eop_i       (in_eop_i),
    .cls_valid_o (cls_push),
    .cls_o       (cls_new)
  );

  tagger_fifo #(.WIDTH(BEAT_W), .DEPTH(DATA_DEPTH)) i_data_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_fire),
    .wdata_i (in_beat),
    .pop_i   (out_fire),
    .rdata_o (head_raw),
    .empty_o (d_empty),
    .full_o  (d_full)
  );

  tagger_fifo #(.WIDTH(CLASS_W), .DEPTH(CLASS_DEPTH)) i_class_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (cls_push),
    .wdata_i (cls_new),
    .pop_i   (out_fire && head.sop),
    .rdata_o (cls_raw),
    .empty_o (c_empty),
    .full_o  (c_full)
  );

  assign head     = beat_t'(head_raw);
  assign cls_head = class_t'(cls_raw);

  // a frame's first byte waits for its class
  assign out_valid_o = !d_empty && (!head.sop || !c_empty);
  assign out_fire    = out_valid_o && out_ready_i;
  assign out_data_o  = head.data;
  assign out_sop_o   = head.sop;
  assign out_eop_o   = head.eop;
  assign out_class_o = head.sop ? cls_head : '0;

endmodule

// File: rtl/tagger_checker.sv
module tagger_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] out_data_o,
  input logic       out_sop_o,
  input logic       out_eop_o,
  input logic [4:0] out_class_o,
  input logic       out_valid_o,
  input logic       out_ready_i
);
  a_r2_one_addr_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sop_o |-> $countones(out_class_o[4:2]) == 1);

  a_r2_bcast_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sop_o && out_class_o[3] |-> out_data_o == 8'hFF);

  a_r3_mcast_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sop_o && out_class_o[2] |-> out_data_o[0]);

  a_r4_ucast_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sop_o && out_class_o[4] |-> !out_data_o[0]);

  a_r6_stack_has_vlan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sop_o && out_class_o[0] |-> out_class_o[1]);

  a_r11_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_sop_o) && $stable(out_eop_o) && $stable(out_class_o));

endmodule

bind frame_class_tagger tagger_checker i_checker (.*);

// File: tb/test_frame_class_tagger.sv
`timescale 1ns/1ps
module test_frame_class_tagger;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_sop_i = 1'b0, in_eop_i = 1'b0, in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] out_data_o;
  logic       out_sop_o, out_eop_o, out_valid_o;
  logic [4:0] out_class_o;
  logic       out_ready_i = 1'b0;

  always #10 clk_i = ~clk_i;

  frame_class_tagger i_frame_class_tagger (.*);

  int checks = 0, failures = 0;
  logic [7:0] q_data[$];
  bit         q_sop[$], q_eop[$];
  int         f_start[$], f_len[$];
  logic [4:0] f_cls[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_class(input int s, input int n);
    bit bc, mc, uc, vl, st;
    logic [15:0] t1, t2;
    bc = (n >= 6);
    for (int i = 0; i < 6 && i < n; i++) bc = bc && (q_data[s+i] == 8'hFF);
    mc = !bc && q_data[s][0];
    uc = !bc && !mc;
    t1 = (n >= 14) ? {q_data[s+12], q_data[s+13]} : 16'h0;
    t2 = (n >= 18) ? {q_data[s+16], q_data[s+17]} : 16'h0;
    st = (n >= 18) && (t1 == 16'h88A8 || t1 == 16'h8100) && t2 == 16'h8100;
    vl = st || (n >= 14 && t1 == 16'h8100);
    return {uc, bc, mc, vl, st};
  endfunction

  task automatic add_frame(input int len, input logic [7:0] b0, input bit bc,
                           input logic [15:0] t1, input logic [15:0] t2);
    int s = q_data.size();
    for (int i = 0; i < len; i++) begin
      logic [7:0] b = 8'($urandom);
      if (i == 0) b = bc ? 8'hFF : b0;
      else if (i < 6 && bc) b = 8'hFF;
      if (i == 12) b = t1[15:8];
      if (i == 13) b = t1[7:0];
      if (i == 16) b = t2[15:8];
      if (i == 17) b = t2[7:0];
      q_data.push_back(b);
      q_sop.push_back(i == 0);
      q_eop.push_back(i == len - 1);
    end
    f_start.push_back(s);
    f_len.push_back(len);
    f_cls.push_back(exp_class(s, len));
  endtask

  initial begin
    int in_ptr = 0, o_ptr = 0, o_frame = 0, cyc = 0, total;
    bit acc = 0, stall = 0;
    logic [7:0] s_data;
    logic [4:0] s_cls;
    bit s_sop, s_eop;
    void'($urandom(32'd2024));

    add_frame(64, 8'h02, 0, 16'h0800, 16'h0000); // R4 unicast
    add_frame(60, 8'h00, 1, 16'h0800, 16'h0000); // R2 broadcast
    add_frame(60, 8'h01, 0, 16'h0800, 16'h0000); // R3 multicast
    add_frame(60, 8'h00, 0, 16'h8100, 16'h0800); // R5 single tag
    add_frame(60, 8'h00, 0, 16'h88A8, 16'h8100); // R6 stacked
    add_frame(60, 8'h03, 0, 16'h8100, 16'h8100); // R6 stacked, ctag outer
    add_frame(60, 8'h00, 0, 16'h88A8, 16'h0800); // R6 outer only
    add_frame(1,  8'h01, 0, 16'h0, 16'h0);       // R10 one byte
    add_frame(5,  8'hFF, 1, 16'h0, 16'h0);       // R10 partial DA
    add_frame(6,  8'hFF, 1, 16'h0, 16'h0);       // R2 exact DA
    add_frame(13, 8'h00, 0, 16'h8100, 16'h0);    // R10 half type
    add_frame(14, 8'h00, 0, 16'h8100, 16'h0);    // R5 exact type
    add_frame(17, 8'h00, 0, 16'h88A8, 16'h8100); // R10 half inner
    add_frame(18, 8'h00, 0, 16'h88A8, 16'h8100); // R6 exact inner
    for (int k = 0; k < 8; k++) add_frame(2, 8'h01, 0, 16'h0, 16'h0);
    for (int k = 0; k < 60; k++) begin
      int kind = $urandom % 3;
      logic [15:0] t1 = (kind == 0) ? 16'h0800 : ($urandom % 2) ? 16'h8100 : 16'h88A8;
      logic [15:0] t2 = ($urandom % 2) ? 16'h8100 : 16'h0800;
      add_frame(1 + int'($urandom % 70), {7'($urandom), kind == 1}, kind == 2, t1, t2);
    end
    total = q_data.size();

    // R1 reset
    repeat (2) @(negedge clk_i);
    chk(out_valid_o == 0, "R1", "out_valid in reset", out_valid_o, 0);
    chk(in_ready_o == 1, "R1", "in_ready in reset", in_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 0, "R1", "out_valid after reset", out_valid_o, 0);
    chk(in_ready_o == 1, "R1", "in_ready after reset", in_ready_o, 1);

    while (o_ptr < total) begin
      int ph = (cyc / 400) % 3;
      @(negedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        chk(0, "R8", "watchdog expired", o_ptr, total);
        break;
      end
      if (acc) in_ptr++;
      in_valid_i = (in_ptr < total) && (($urandom % 100) < (ph == 0 ? 100 : ph == 1 ? 70 : 90));
      in_data_i  = (in_ptr < total) ? q_data[in_ptr] : 8'h00;
      in_sop_i   = (in_ptr < total) ? q_sop[in_ptr] : 1'b0;
      in_eop_i   = (in_ptr < total) ? q_eop[in_ptr] : 1'b0;
      out_ready_i = ($urandom % 100) < (ph == 0 ? 100 : ph == 1 ? 60 : 20);
      #1;
      acc = in_valid_i && in_ready_o;
      if (stall) begin
        chk(out_valid_o == 1, "R11", "valid dropped in stall", out_valid_o, 1);
        chk(out_data_o == s_data && out_sop_o == s_sop && out_eop_o == s_eop
            && out_class_o == s_cls, "R11", "beat changed in stall", out_data_o, s_data);
      end
      if (out_valid_o && out_ready_i) begin
        chk(out_data_o == q_data[o_ptr], "R8", "data", out_data_o, q_data[o_ptr]);
        chk(out_sop_o == q_sop[o_ptr] && out_eop_o == q_eop[o_ptr], "R8", "sop/eop",
            {out_sop_o, out_eop_o}, {q_sop[o_ptr], q_eop[o_ptr]});
        if (out_sop_o) begin
          int need = (f_len[o_frame] < 18) ? f_len[o_frame] : 18;
          chk(in_ptr >= f_start[o_frame] + need, "R9", "early first byte",
              in_ptr, f_start[o_frame] + need);
          chk(out_class_o == f_cls[o_frame], "R2 R3 R4 R5 R6 R10", "class",
              out_class_o, f_cls[o_frame]);
          o_frame++;
        end else begin
          chk(out_class_o == 5'h0, "R7", "class off first byte", out_class_o, 0);
        end
        o_ptr++;
      end
      stall = out_valid_o && !out_ready_i;
      s_data = out_data_o; s_sop = out_sop_o; s_eop = out_eop_o; s_cls = out_class_o;
    end

    @(negedge clk_i);
    in_valid_i = 1'b0;
    out_ready_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(out_valid_o == 0, "R8", "extra byte after drain", out_valid_o, 0);
    chk(o_frame == f_len.size(), "R8", "frame count", o_frame, f_len.size());

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule